// File: doc/BRIEF.md
# Buffered Asynchronous Serial Port

This block is a full-duplex asynchronous serial port for a small microcontroller register bus. Software sees two byte-wide addresses. The data address works in two directions. A write loads the transmit shifter and starts a frame on the TX pin. A read returns a receive latch that holds the last completed byte. The transmit data can never be read back. The control address holds these fields:

- the frame length selection, 8 or 9 data bits;
- the receive enable;
- the interrupt enable;
- the ninth bit to be sent;
- the ninth bit captured from the line;
- two sticky event flags, one for transmit and one for receive.

The transmitter and the receiver run at the same time and do not depend on each other. Both take their timing from an external baud tick that runs at sixteen times the bit rate. The receive input shifter is preset to all ones when each reception begins. A finished byte moves into the latch, so the next frame can be received before software has read the previous byte. Hardware only sets the event flags. Software clears them by writing the control address, and it learns the cause of an interrupt from which flag is set. The interrupt request output is the single combined request.

Top module: `sio_port`

## Requirements
- R1: After reset, TX is high, the control address reads 0x00, the data address reads 0x00 and irq is low.
- R2: A write to the data address (regAddr=0) starts a frame on the next clock. The frame is a low start bit, then the data bits LSB first, then a high stop bit. Each bit lasts exactly 16 baud ticks. In 8-bit mode (control bit 5 = 0) the frame has 8 data bits. A new write restarts the frame at once.
- R3: In 9-bit mode (control bit 5 = 1), the value of control bit 2 is sent as a ninth data bit between data bit 7 and the stop bit.
- R4: The transmit flag (control bit 0) becomes 1 in the cycle after the stop bit's 16th tick. It then stays 1 until software writes a 0 to that bit.
- R5: A read of the data address returns the receive latch and never the last transmitted byte.
- R6: In 8-bit mode, a start bit that is still low at mid-bit begins a reception. Each later bit is sampled at its centre, LSB first. At the stop-bit sample the byte is loaded into the latch, the stop level goes to control bit 3, and the receive flag (control bit 1) is set.
- R7: In 9-bit mode, the ninth received data bit is captured into control bit 3, and the latch holds the first 8 bits.
- R8: A low pulse on RX that has ended before mid-bit is rejected as a glitch. The latch and the receive flag are left unchanged.
- R9: While receive enable (control bit 4) is 0, a completed frame changes neither the latch, nor control bit 3, nor the receive flag.
- R10: If the receive flag is still set when another frame completes, the latch is overwritten with the new byte and the flag stays set.
- R11: irq equals interrupt enable (control bit 6) AND (transmit flag OR receive flag).
- R12: A reception that overlaps a transmission completes correctly, and the transmission is not disturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 1 | Register select: 0 selects data, 1 selects control |
| regWr | input | 1 | Write strobe, one cycle per write |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for the selected address (combinational) |
| baudTick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxPin | input | 1 | Serial receive line, idle high |
| txPin | output | 1 | Serial transmit line, idle high |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions take the baud tick to be a one-cycle pulse. They take a control write never to fall in the same cycle as a data write, which holds because the bus carries a single address. They also take RX to change on a time scale set by the baud tick. The stimulus keeps within these limits. Its tick comes every fourth clock. Each RX bit is held for 64 clocks. Every register access lasts one cycle, and the glitch pulse is kept to three ticks, well short of mid-bit. The transmit line and the transmit flag are compared on every clock against a bit-queue model. Reception is checked through the data and control reads once each frame has ended.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DATA_BITS  = 8;
  localparam int OVERSAMPLE = 16;
  localparam int OS_W       = $clog2(OVERSAMPLE);
  localparam int HALF       = OVERSAMPLE / 2;
  localparam int FRAME_W    = DATA_BITS + 3;
  localparam int RX_W       = DATA_BITS + 1;
  localparam int IDX_W      = $clog2(DATA_BITS + 2);

  localparam int B_TXFLAG = 0;
  localparam int B_RXFLAG = 1;
  localparam int B_TXNINE = 2;
  localparam int B_RXNINE = 3;
  localparam int B_RXEN   = 4;
  localparam int B_MODE9  = 5;
  localparam int B_IRQEN  = 6;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA} rxState_t;

  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic txDone;
    logic rxPreset;
    logic rxShift;
    logic rxLoad;
  } strobe_t;
endpackage

// File: rtl/sio_ctl.sv
module sio_ctl
  import sio_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    baudTick,
  input  logic    wrData,
  input  logic    rxSync,
  input  logic    mode9,
  input  logic    txLastBit,
  output logic    txBusy,
  output strobe_t stb
);
  logic [OS_W-1:0]  txCnt;
  logic [OS_W-1:0]  rxCnt;
  logic [IDX_W-1:0] rxIdx;
  logic [IDX_W-1:0] lastIdx;
  rxState_t         rxState;
  logic             txBitEnd;
  logic             rxMid;
  logic             rxSample;

  assign txBitEnd = txBusy && baudTick && !wrData && (txCnt == OS_W'(OVERSAMPLE - 1));
  assign lastIdx  = mode9 ? IDX_W'(DATA_BITS + 1) : IDX_W'(DATA_BITS);
  assign rxMid    = (rxState == RX_START) && baudTick && (rxCnt == OS_W'(HALF - 1));
  assign rxSample = (rxState == RX_DATA) && baudTick && (rxCnt == OS_W'(OVERSAMPLE - 1));

  always_comb begin
    stb          = '0;
    stb.loadTx   = wrData;
    stb.shiftTx  = txBitEnd && !txLastBit;
    stb.txDone   = txBitEnd && txLastBit;
    stb.rxPreset = rxMid && !rxSync;
    stb.rxShift  = rxSample && (rxIdx <= IDX_W'(DATA_BITS));
    stb.rxLoad   = rxSample && (rxIdx == lastIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txCnt  <= '0;
    end else if (wrData) begin
      txBusy <= 1'b1;
      txCnt  <= '0;
    end else if (txBusy && baudTick) begin
      txCnt <= (txCnt == OS_W'(OVERSAMPLE - 1)) ? '0 : txCnt + 1'b1;
      if (txBitEnd && txLastBit) txBusy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxCnt   <= '0;
      rxIdx   <= '0;
    end else if (baudTick) begin
      case (rxState)
        RX_IDLE: if (!rxSync) begin
          rxState <= RX_START;
          rxCnt   <= '0;
        end
        RX_START: if (rxCnt == OS_W'(HALF - 1)) begin
          rxState <= rxSync ? RX_IDLE : RX_DATA;
          rxCnt   <= '0;
          rxIdx   <= '0;
        end else begin
          rxCnt <= rxCnt + 1'b1;
        end
        RX_DATA: if (rxCnt == OS_W'(OVERSAMPLE - 1)) begin
          rxCnt <= '0;
          rxIdx <= rxIdx + 1'b1;
          if (rxIdx == lastIdx) rxState <= RX_IDLE;
        end else begin
          rxCnt <= rxCnt + 1'b1;
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  // R2: at most one transmit action per cycle
  assert_tx_strobe_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadTx, stb.shiftTx, stb.txDone}));

  // R6: a reception never shifts past the data field plus one sample
  assert_rx_idx_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_DATA) |-> (rxIdx <= IDX_W'(DATA_BITS + 1)));
endmodule

// File: rtl/sio_dp.sv
module sio_dp
  import sio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic                 txBusy,
  input  logic                 regAddr,
  input  logic                 regWr,
  input  logic [DATA_BITS-1:0] regWdata,
  input  logic                 rxPin,
  output logic                 rxSync,
  output logic                 txLine,
  output logic                 txLastBit,
  output logic                 mode9,
  output logic [DATA_BITS-1:0] regRdata,
  output logic                 irq
);
  logic [FRAME_W-1:0]   txShift;
  logic [RX_W-1:0]      rxShift;
  logic [RX_W-1:0]      rxShiftNext;
  logic [DATA_BITS-1:0] rxLatch;
  logic [1:0]           rxMeta;
  logic                 txFlag, rxFlag, txNine, rxNine, rxEn, irqEn;
  logic                 wrCtl;
  logic [7:0]           ctlByte;

  assign wrCtl       = regWr && regAddr;
  assign rxSync      = rxMeta[1];
  assign txLastBit   = (txShift[FRAME_W-1:1] == '0);
  assign txLine      = txBusy ? txShift[0] : 1'b1;
  assign rxShiftNext = stb.rxShift ? {rxSync, rxShift[RX_W-1:1]} : rxShift;
  assign ctlByte     = {1'b0, irqEn, mode9, rxEn, rxNine, txNine, rxFlag, txFlag};
  assign regRdata    = regAddr ? DATA_BITS'(ctlByte) : rxLatch;
  assign irq         = irqEn && (txFlag || rxFlag);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxMeta <= 2'b11;
    else       rxMeta <= {rxMeta[0], rxPin};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= FRAME_W'(1);
    end else if (stb.loadTx) begin
      txShift <= mode9 ? {1'b1, txNine, regWdata, 1'b0}
                       : {1'b0, 1'b1, regWdata, 1'b0};
    end else if (stb.shiftTx) begin
      txShift <= {1'b0, txShift[FRAME_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '1;
    end else if (stb.rxPreset) begin
      rxShift <= '1;
    end else begin
      rxShift <= rxShiftNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxLatch <= '0;
      rxNine  <= 1'b0;
    end else if (stb.rxLoad && rxEn) begin
      rxLatch <= rxShiftNext[DATA_BITS-1:0];
      rxNine  <= rxShiftNext[RX_W-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txFlag <= 1'b0;
      rxFlag <= 1'b0;
      txNine <= 1'b0;
      rxEn   <= 1'b0;
      mode9  <= 1'b0;
      irqEn  <= 1'b0;
    end else begin
      if (stb.txDone)                txFlag <= 1'b1;
      else if (wrCtl)                txFlag <= regWdata[B_TXFLAG];
      if (stb.rxLoad && rxEn)        rxFlag <= 1'b1;
      else if (wrCtl)                rxFlag <= regWdata[B_RXFLAG];
      if (wrCtl) begin
        txNine <= regWdata[B_TXNINE];
        rxEn   <= regWdata[B_RXEN];
        mode9  <= regWdata[B_MODE9];
        irqEn  <= regWdata[B_IRQEN];
      end
    end
  end

  assert_tx_done_sets_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.txDone |=> txFlag);

  assert_tx_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txFlag && !wrCtl) |=> txFlag);

  assert_rx_load_sets_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rxLoad && rxEn) |=> rxFlag);

  assert_rx_disabled_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> $stable(rxLatch));

  assert_tx_line_steady_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.loadTx && !stb.shiftTx) |=> $stable(txLine));
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regAddr,
  input  logic                 regWr,
  input  logic [DATA_BITS-1:0] regWdata,
  output logic [DATA_BITS-1:0] regRdata,
  input  logic                 baudTick,
  input  logic                 rxPin,
  output logic                 txPin,
  output logic                 irq
);
  strobe_t stb;
  logic    txBusy, rxSync, mode9, txLastBit, wrData;

  assign wrData = regWr && !regAddr;

  sio_ctl ctl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .wrData(wrData),
    .rxSync(rxSync), .mode9(mode9), .txLastBit(txLastBit),
    .txBusy(txBusy), .stb(stb)
  );

  sio_dp dp (
    .clk(clk), .rstN(rstN), .stb(stb), .txBusy(txBusy),
    .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata),
    .rxPin(rxPin), .rxSync(rxSync), .txLine(txPin), .txLastBit(txLastBit),
    .mode9(mode9), .regRdata(regRdata), .irq(irq)
  );
endmodule

// File: tb/sio_port_test.sv
module sio_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regAddr = 1'b1;
  logic       regWr = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       baudTick = 1'b0;
  logic       rxPin = 1'b1;
  logic       txPin;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  sio_port uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .baudTick(baudTick),
    .rxPin(rxPin), .txPin(txPin), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int tickDiv = 0;
  always @(negedge clk) begin
    if (!rstN) begin
      tickDiv  = 0;
      baudTick = 1'b0;
    end else begin
      tickDiv  = (tickDiv + 1) % 4;
      baudTick = (tickDiv == 0);
    end
  end

  // transmit reference: a queue of line levels, each held for 16 ticks
  bit mQ[$];
  int mCnt;
  bit mActive, mTxFlag, mMode9, mTxNine;

  always @(posedge clk) begin
    if (!rstN) begin
      mQ.delete(); mCnt = 0; mActive = 0; mTxFlag = 0; mMode9 = 0; mTxNine = 0;
    end else begin
      if (regWr && regAddr) begin
        mTxFlag = regWdata[0]; mTxNine = regWdata[2]; mMode9 = regWdata[5];
      end
      if (regWr && !regAddr) begin
        mQ.delete();
        mQ.push_back(1'b0);
        for (int i = 0; i < 8; i++) mQ.push_back(regWdata[i]);
        if (mMode9) mQ.push_back(mTxNine);
        mQ.push_back(1'b1);
        mActive = 1; mCnt = 0;
      end else if (mActive && baudTick) begin
        mCnt++;
        if (mCnt == 16) begin
          mCnt = 0;
          void'(mQ.pop_front());
          if (mQ.size() == 0) begin mActive = 0; mTxFlag = 1; end
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_PERIOD / 4);
    if (rstN && !finished) begin
      bit expLine;
      expLine = mActive ? mQ[0] : 1'b1;
      check(txPin == expLine, mMode9 ? "R3 tx line" : "R2 tx line", txPin, expLine);
      if (regAddr && !regWr)
        check(regRdata[0] == mTxFlag, "R4 tx flag", regRdata[0], mTxFlag);
    end
  end

  task automatic writeReg(input bit a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWr = 1'b1; regWdata = d;
    @(negedge clk); regWr = 1'b0; regAddr = 1'b1;
  endtask

  task automatic readReg(input bit a, output logic [7:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdata; regAddr = 1'b1;
  endtask

  task automatic sendRx(input logic [7:0] d, input bit nine, input bit hasNine);
    rxPin = 1'b0; repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxPin = d[i]; repeat (BIT_CLKS) @(negedge clk); end
    if (hasNine) begin rxPin = nine; repeat (BIT_CLKS) @(negedge clk); end
    rxPin = 1'b1; repeat (2 * BIT_CLKS) @(negedge clk);
  endtask

  task automatic waitTxIdle();
    @(negedge clk);
    while (mActive) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] rd;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txPin == 1'b1, "R1 tx idle", txPin, 1);
    readReg(1, rd); check(rd == 8'h00, "R1 control", rd, 8'h00);
    readReg(0, rd); check(rd == 8'h00, "R1 data", rd, 8'h00);
    check(irq == 1'b0, "R1 irq", irq, 0);

    writeReg(1, 8'h10);
    writeReg(0, 8'hA5);
    repeat (200) @(negedge clk);
    writeReg(0, 8'h3E);
    waitTxIdle();
    repeat (200) @(negedge clk);
    readReg(1, rd); check(rd[0] == 1'b1, "R4 flag sticky", rd[0], 1);
    readReg(0, rd); check(rd == 8'h00, "R5 data read is rx latch", rd, 8'h00);
    check(irq == 1'b0, "R11 irq masked", irq, 0);
    writeReg(1, 8'h51);
    check(irq == 1'b1, "R11 irq on tx flag", irq, 1);
    writeReg(1, 8'h50);
    readReg(1, rd); check(rd[0] == 1'b0, "R4 flag cleared", rd[0], 0);
    check(irq == 1'b0, "R11 irq cleared", irq, 0);

    sendRx(8'h3C, 1'b0, 1'b0);
    readReg(0, rd); check(rd == 8'h3C, "R6 rx byte", rd, 8'h3C);
    readReg(1, rd); check(rd[1] == 1'b1, "R6 rx flag", rd[1], 1);
    check(rd[3] == 1'b1, "R6 stop level in bit3", rd[3], 1);
    check(irq == 1'b1, "R11 irq on rx flag", irq, 1);

    sendRx(8'h81, 1'b0, 1'b0);
    readReg(0, rd); check(rd == 8'h81, "R10 overwrite", rd, 8'h81);
    readReg(1, rd); check(rd[1] == 1'b1, "R10 flag kept", rd[1], 1);
    writeReg(1, 8'h50);

    rxPin = 1'b0; repeat (12) @(negedge clk); rxPin = 1'b1;
    repeat (6 * BIT_CLKS) @(negedge clk);
    readReg(0, rd); check(rd == 8'h81, "R8 glitch latch", rd, 8'h81);
    readReg(1, rd); check(rd[1] == 1'b0, "R8 glitch flag", rd[1], 0);

    writeReg(1, 8'h40);
    sendRx(8'h55, 1'b0, 1'b0);
    readReg(0, rd); check(rd == 8'h81, "R9 latch held", rd, 8'h81);
    readReg(1, rd); check(rd[1] == 1'b0, "R9 flag held", rd[1], 0);

    writeReg(1, 8'h34);
    writeReg(0, 8'h0F);
    sendRx(8'hC3, 1'b0, 1'b1);
    waitTxIdle();
    readReg(0, rd); check(rd == 8'hC3, "R12 rx during tx", rd, 8'hC3);
    readReg(1, rd); check(rd[3] == 1'b0, "R7 ninth bit zero", rd[3], 0);
    check(rd[0] == 1'b1, "R12 tx completed", rd[0], 1);

    writeReg(1, 8'h30);
    writeReg(0, 8'hF0);
    sendRx(8'h00, 1'b1, 1'b1);
    waitTxIdle();
    readReg(0, rd); check(rd == 8'h00, "R7 rx data", rd, 8'h00);
    readReg(1, rd); check(rd[3] == 1'b1, "R7 ninth bit one", rd[3], 1);

    repeat (10) @(negedge clk);
    summary();
  end
endmodule